// File: doc/BRIEF.md
# Paged Memory Block-Access Sequencer

This block sits between a command decoder and a page-organised store of 64 words of 32 bits. Each group of four consecutive pages forms a block. The decoder hands over one command at a time. A command names a direction (read or write), a span (one page, or the rest of the enclosing block) and an 8-bit page address. The sequencer then walks the pages. On a read it streams the stored bytes out. On a write it paces the incoming bytes, programs the store one page at a time, and raises an acknowledge event for each confirmed step.

A write follows a fixed rhythm of handshakes. First the command itself is confirmed. A settle window follows, and bytes offered during it are dropped. Then the first page's four bytes arrive, least significant byte first, with a CRC verdict flag on the fourth byte. A programming interval follows with a busy flag held high. At its end the page is committed, then confirmed. A block write repeats the settle, collect, program and confirm steps for each page up to the end of the block. A bad CRC verdict ends the command at once. The serial coding and the CRC arithmetic are done by the neighbours.

Top module: `blkseq_top`

## Requirements
- R1: After reset, cmd_ready is 1, and rd_valid, ack_valid, wr_stb and busy are 0. Every page of the store reads back as zero.
- R2: A command whose page address is 64 or more (either of bits 7:6 set) is dropped. It gives no acknowledge, no read output and no store change, and cmd_ready stays 1 in the following cycle.
- R3: A single-page read outputs the page's 4 bytes on 4 consecutive cycles, starting in the cycle after acceptance. The bytes come in the order bits 7:0, 15:8, 23:16, 31:24. rd_last is 1 only with the final byte.
- R4: A block read from page p outputs pages p through the page whose two low address bits are 11, in ascending order. That is 4 to 16 bytes, with rd_last only on the final byte of the final page.
- R5: An accepted write command gives ack_valid for one cycle in the cycle after acceptance, with ack_code equal to 2'b01.
- R6: After each acknowledge of a write, bytes offered during the acknowledge cycle and the next TWSC cycles are ignored. After that, bytes offered during programming are also ignored. The first accepted byte of a page becomes bits 7:0 of the word.
- R7: After the fourth byte of a page with a good CRC verdict, busy is 1 for exactly TPROG cycles. wr_stb pulses with wr_page in the last of those cycles, and ack_valid with code 2'b01 follows in the next cycle.
- R8: A single-page write stores the assembled word, and a later read returns it.
- R9: A block write from page p programs and acknowledges pages p through the end of the block, one at a time in ascending order.
- R10: A CRC verdict of 0 on the fourth byte of a page ends the write. That page and all later pages are left unchanged, no acknowledge follows, and cmd_ready is 1 in the next cycle.
- R11: A command offered while cmd_ready is 0 is ignored and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_block | input | 1 | 1 = run to end of block, 0 = single page |
| cmd_page | input | 8 | Start page address |
| cmd_ready | output | 1 | Idle and able to accept a command |
| wb_valid | input | 1 | Write byte offered |
| wb_byte | input | 8 | Write byte, least significant byte of a page first |
| wb_crc_ok | input | 1 | CRC verdict, sampled with the fourth byte of a page |
| rd_valid | output | 1 | Read byte valid |
| rd_page | output | 6 | Page the read byte belongs to |
| rd_byte | output | 8 | Read byte |
| rd_last | output | 1 | Final byte of the read command |
| ack_valid | output | 1 | Acknowledge event |
| ack_code | output | 2 | Acknowledge pattern, 2'b01 when valid |
| wr_stb | output | 1 | Page commit strobe |
| wr_page | output | 6 | Page being committed |
| busy | output | 1 | Programming interval in progress |

## Verification
The bench builds the block with TWSC set to 3 and TPROG set to 5. With these short windows, every settle window and programming interval of a full four-page block write fits in a few dozen cycles. This makes it possible to feed junk bytes through every ignored window and to measure the exact busy length on each page. The default store geometry is kept, so block boundaries at the top of the address space (pages 60 to 63) and the out-of-range addresses just above it can be reached directly.

// File: rtl/blkseq_pkg.sv
// Shared types for the block-access sequencer.
// Assumes: a single clock domain; all users import this package.
package blkseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,   // waiting for a command
        S_RD,     // streaming read bytes
        S_ACKC,   // confirming a write command
        S_WAIT,   // settle window before write data
        S_DATA,   // collecting the four bytes of a page
        S_PROG,   // programming interval
        S_ACKP    // confirming a programmed page
    } seq_state_t;

    localparam logic [1:0] ACK_PATTERN = 2'b01;

endpackage

// File: rtl/blkseq_timer.sv
// Down-counter for the settle and programming windows.
// Assumes: load has priority; the counter holds at zero until reloaded.
module blkseq_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);

    logic [CW-1:0] cnt;

    // Load a new window length or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/blkseq_range.sv
// Computes the final page a command visits.
// Assumes: block size is a power of two, given as BLK_SH address bits.
module blkseq_range #(
    parameter int PG_W   = 6,
    parameter int BLK_SH = 2
) (
    input  logic [PG_W-1:0] start_pg,
    input  logic            block,
    output logic [PG_W-1:0] last_pg
);

    generate
        if (BLK_SH == 0) begin : g_no_block
            // A one-page block always ends where it starts.
            assign last_pg = start_pg;
        end else begin : g_block
            // A block span ends at the page with all in-block bits set.
            assign last_pg = block ? {start_pg[PG_W-1:BLK_SH], {BLK_SH{1'b1}}}
                                   : start_pg;
        end
    endgenerate

endmodule

// File: rtl/blkseq_mem.sv
// Register-array page store with one write port and one read port.
// Assumes: clears to zero on reset; the read port is combinational.
module blkseq_mem #(
    parameter int PAGES = 64,
    parameter int WORD  = 32,
    localparam int PG_W = $clog2(PAGES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [PG_W-1:0] waddr,
    input  logic [WORD-1:0] wdata,
    input  logic [PG_W-1:0] raddr,
    output logic [WORD-1:0] rdata
);

    logic [WORD-1:0] store [PAGES];

    // Clear on reset, otherwise commit one page per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGES; i++) store[i] <= '0;
        end else if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/blkseq_top.sv
// Block-access sequencer: walks single-page or rest-of-block reads and
// writes over the page store, pacing write data with a settle window
// and a programming interval, and raising one acknowledge per step.
// Assumes: one command in flight; the CRC verdict arrives with byte 4.
module blkseq_top #(
    parameter int PAGES         = 64,
    parameter int WORD          = 32,
    parameter int PAGES_PER_BLK = 4,
    parameter int ADDR_W        = 8,
    parameter int TWSC          = 3,
    parameter int TPROG         = 5,
    localparam int PG_W   = $clog2(PAGES),
    localparam int BLK_SH = $clog2(PAGES_PER_BLK),
    localparam int BYTES  = WORD / 8,
    localparam int BI_W   = (BYTES > 1) ? $clog2(BYTES) : 1,
    localparam int TMAX   = (TWSC > TPROG) ? TWSC : TPROG,
    localparam int CW     = $clog2(TMAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic              cmd_block,
    input  logic [ADDR_W-1:0] cmd_page,
    output logic              cmd_ready,
    input  logic              wb_valid,
    input  logic [7:0]        wb_byte,
    input  logic              wb_crc_ok,
    output logic              rd_valid,
    output logic [PG_W-1:0]   rd_page,
    output logic [7:0]        rd_byte,
    output logic              rd_last,
    output logic              ack_valid,
    output logic [1:0]        ack_code,
    output logic              wr_stb,
    output logic [PG_W-1:0]   wr_page,
    output logic              busy
);
    import blkseq_pkg::*;

    seq_state_t      state;
    logic [PG_W-1:0] cur_pg, end_pg, span_end;
    logic [BI_W-1:0] byte_idx;
    logic [WORD-1:0] asm_word, mem_rdata;
    logic            tmr_load, tmr_zero;
    logic [CW-1:0]   tmr_val;
    logic            addr_ok, last_byte, at_end;

    assign addr_ok   = (cmd_page < ADDR_W'(PAGES));
    assign last_byte = (byte_idx == BI_W'(BYTES - 1));
    assign at_end    = (cur_pg == end_pg);

    blkseq_range #(.PG_W(PG_W), .BLK_SH(BLK_SH)) range_i (
        .start_pg (cmd_page[PG_W-1:0]),
        .block    (cmd_block),
        .last_pg  (span_end)
    );

    // Window loads: settle after each acknowledge that leads to data,
    // programming after a page's fourth byte with a good verdict.
    always_comb begin
        tmr_load = (state == S_ACKC) ||
                   (state == S_ACKP && !at_end) ||
                   (state == S_DATA && wb_valid && last_byte && wb_crc_ok);
        tmr_val  = (state == S_DATA) ? CW'(TPROG - 1) : CW'(TWSC - 1);
    end

    blkseq_timer #(.CW(CW)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    blkseq_mem #(.PAGES(PAGES), .WORD(WORD)) mem_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_stb),
        .waddr (cur_pg),
        .wdata (asm_word),
        .raddr (cur_pg),
        .rdata (mem_rdata)
    );

    // Sequencing of pages, bytes and handshake steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cur_pg   <= '0;
            end_pg   <= '0;
            byte_idx <= '0;
            asm_word <= '0;
        end else begin
            case (state)
                S_IDLE: if (cmd_valid && addr_ok) begin
                    cur_pg   <= cmd_page[PG_W-1:0];
                    end_pg   <= span_end;
                    byte_idx <= '0;
                    state    <= cmd_write ? S_ACKC : S_RD;
                end
                S_RD: begin
                    byte_idx <= last_byte ? '0 : byte_idx + 1'b1;
                    if (last_byte) begin
                        if (at_end) state  <= S_IDLE;
                        else        cur_pg <= cur_pg + 1'b1;
                    end
                end
                S_ACKC: state <= S_WAIT;
                S_WAIT: if (tmr_zero) begin
                    byte_idx <= '0;
                    state    <= S_DATA;
                end
                S_DATA: if (wb_valid) begin
                    asm_word <= {wb_byte, asm_word[WORD-1:8]};
                    byte_idx <= last_byte ? '0 : byte_idx + 1'b1;
                    if (last_byte) state <= wb_crc_ok ? S_PROG : S_IDLE;
                end
                S_PROG: if (tmr_zero) state <= S_ACKP;
                S_ACKP: begin
                    if (at_end) begin
                        state <= S_IDLE;
                    end else begin
                        cur_pg <= cur_pg + 1'b1;
                        state  <= S_WAIT;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Port views of the sequencer state.
    always_comb begin
        cmd_ready = (state == S_IDLE);
        rd_valid  = (state == S_RD);
        rd_page   = cur_pg;
        rd_byte   = mem_rdata[byte_idx*8 +: 8];
        rd_last   = rd_valid && last_byte && at_end;
        ack_valid = (state == S_ACKC) || (state == S_ACKP);
        ack_code  = ack_valid ? ACK_PATTERN : 2'b00;
        busy      = (state == S_PROG);
        wr_stb    = busy && tmr_zero;
        wr_page   = cur_pg;
    end

endmodule

// File: rtl/blkseq_checker.sv
// Port-level properties of the block-access sequencer.
// Assumes: attached to every blkseq_top instance through the bind below.
module blkseq_checker #(
    parameter int PAGES         = 64,
    parameter int PAGES_PER_BLK = 4,
    parameter int ADDR_W        = 8,
    parameter int TPROG         = 5,
    localparam int PG_W   = $clog2(PAGES),
    localparam int BLK_SH = $clog2(PAGES_PER_BLK)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_write,
    input logic [ADDR_W-1:0] cmd_page,
    input logic              cmd_ready,
    input logic              rd_valid,
    input logic [PG_W-1:0]   rd_page,
    input logic              rd_last,
    input logic              ack_valid,
    input logic [1:0]        ack_code,
    input logic              wr_stb,
    input logic              busy
);

    logic [15:0] busy_run;

    // Count the busy cycles that came before the current one.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else           busy_run <= '0;
    end

    a_r2_range_abort: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && (cmd_page >= ADDR_W'(PAGES))
        |=> cmd_ready && !ack_valid && !rd_valid);

    a_r3_last_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |=> cmd_ready && !rd_valid);

    a_r4_stay_in_block: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && $past(rd_valid)
        |-> rd_page[PG_W-1:BLK_SH] == $past(rd_page[PG_W-1:BLK_SH]));

    a_r5_cmd_ack: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && cmd_write && (cmd_page < ADDR_W'(PAGES))
        |=> ack_valid && ack_code == 2'b01);

    a_r7_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> busy && busy_run == 16'(TPROG - 1));

    a_r7_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> ack_valid && !busy);

    a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid || ack_valid || busy) |-> !cmd_ready);

endmodule

bind blkseq_top blkseq_checker #(
    .PAGES(PAGES), .PAGES_PER_BLK(PAGES_PER_BLK), .ADDR_W(ADDR_W), .TPROG(TPROG)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_page(cmd_page), .cmd_ready(cmd_ready), .rd_valid(rd_valid),
    .rd_page(rd_page), .rd_last(rd_last), .ack_valid(ack_valid),
    .ack_code(ack_code), .wr_stb(wr_stb), .busy(busy)
);

// File: tb/blkseq_top_tb_top.sv
// Scoreboard bench: driver tasks queue expected events, a monitor
// compares what the sequencer produces against them.
module blkseq_top_tb_top;

    localparam int TWSC  = 3;
    localparam int TPROG = 5;
    localparam int K_RD = 1, K_ACK = 2, K_WR = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0, cmd_write = 1'b0, cmd_block = 1'b0;
    logic [7:0] cmd_page = '0;
    logic       cmd_ready;
    logic       wb_valid = 1'b0, wb_crc_ok = 1'b1;
    logic [7:0] wb_byte = '0;
    logic       rd_valid, rd_last, ack_valid, wr_stb, busy;
    logic [5:0] rd_page, wr_page;
    logic [7:0] rd_byte;
    logic [1:0] ack_code;

    always #5 clk = ~clk;

    blkseq_top #(.TWSC(TWSC), .TPROG(TPROG)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_block(cmd_block), .cmd_page(cmd_page), .cmd_ready(cmd_ready),
        .wb_valid(wb_valid), .wb_byte(wb_byte), .wb_crc_ok(wb_crc_ok),
        .rd_valid(rd_valid), .rd_page(rd_page), .rd_byte(rd_byte),
        .rd_last(rd_last), .ack_valid(ack_valid), .ack_code(ack_code),
        .wr_stb(wr_stb), .wr_page(wr_page), .busy(busy)
    );

    typedef struct {
        int    kind;
        int    page;
        int    val;
        int    last;
        string req;
    } exp_t;

    exp_t        sb[$];
    int          n_run = 0, n_fail = 0;
    logic [31:0] ref_mem [64];
    int          busy_run = 0;
    bit          mon_on = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic void push(int kind, int page, int val, int last, string req);
        exp_t e;
        e.kind = kind; e.page = page; e.val = val; e.last = last; e.req = req;
        sb.push_back(e);
    endfunction

    function automatic longint pack(int kind, int page, int val, int last);
        return (longint'(kind) << 32) | (longint'(last) << 24) |
               (longint'(page) << 16) | longint'(val);
    endfunction

    task automatic match(input int kind, input int page, input int val, input int last);
        exp_t e;
        if (sb.size() == 0) begin
            check(1'b0, "R11", "unexpected output event", pack(kind, page, val, last), 0);
        end else begin
            e = sb.pop_front();
            check(e.kind == kind && e.page == page && e.val == val && e.last == last,
                  e.req, "event", pack(kind, page, val, last),
                  pack(e.kind, e.page, e.val, e.last));
        end
    endtask

    // Monitor: compares every produced event with the queue head.
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if (rd_valid)  match(K_RD, int'(rd_page), int'(rd_byte), int'(rd_last));
            if (ack_valid) match(K_ACK, 0, int'(ack_code), 0);
            if (wr_stb) begin
                match(K_WR, int'(wr_page), 0, 0);
                check(busy && busy_run == TPROG - 1, "R7", "busy length before strobe",
                      busy_run + 1, TPROG);
            end
            busy_run = busy ? busy_run + 1 : 0;
        end
    end

    function automatic logic [31:0] word_for(int pg, int seed);
        return {8'(pg + 8'h11), 8'(seed), 8'(pg ^ seed ^ 8'h5A), 8'(~pg)};
    endfunction

    task automatic send_cmd(input bit wr, input bit blk, input logic [7:0] pg);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_write = wr; cmd_block = blk; cmd_page = pg;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        repeat (2) @(negedge clk);
        check(sb.size() == 0, req, "events left unseen", sb.size(), 0);
    endtask

    task automatic do_read(input logic [7:0] pg, input bit blk, input string req);
        int last = blk ? (int'(pg) | 3) : int'(pg);
        for (int p = int'(pg); p <= last; p++)
            for (int b = 0; b < 4; b++)
                push(K_RD, p, int'(ref_mem[p][8*b +: 8]), (p == last && b == 3), req);
        send_cmd(1'b0, blk, pg);
        @(negedge clk);
        check(rd_valid == 1'b1, "R3", "read starts one cycle after accept", rd_valid, 1);
        wait_idle(req);
    endtask

    // Block or page write; bad_pg < 0 means every verdict is good;
    // poke offers a read command during the first settle window.
    task automatic do_write(input logic [7:0] pg, input bit blk, input int seed,
                            input int bad_pg, input bit poke, input string req);
        int last = blk ? (int'(pg) | 3) : int'(pg);
        push(K_ACK, 0, 1, 0, "R5");
        for (int p = int'(pg); p <= last; p++) begin
            if (p == bad_pg) break;
            push(K_WR, p, 0, 0, req);
            push(K_ACK, 0, 1, 0, "R7");
        end
        send_cmd(1'b1, blk, pg);
        wb_valid = 1'b1; wb_byte = 8'hEE;
        for (int p = int'(pg); p <= last; p++) begin
            logic [31:0] w = word_for(p, seed);
            @(negedge clk);
            while (!ack_valid) @(negedge clk);
            @(posedge clk); #1;
            if (poke && p == int'(pg)) begin
                cmd_valid = 1'b1; cmd_write = 1'b0; cmd_page = 8'h00;
            end
            repeat (TWSC) begin @(posedge clk); #1; end
            cmd_valid = 1'b0;
            for (int b = 0; b < 4; b++) begin
                wb_byte   = w[8*b +: 8];
                wb_crc_ok = (b == 3) ? (p != bad_pg) : 1'b1;
                @(posedge clk); #1;
            end
            wb_crc_ok = 1'b1; wb_byte = 8'hEE;
            if (p == bad_pg) begin
                wb_valid = 1'b0;
                @(negedge clk);
                check(cmd_ready == 1'b1, "R10", "ready after bad verdict", cmd_ready, 1);
                break;
            end
            ref_mem[p] = w;
        end
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        wb_valid = 1'b0;
        wait_idle(req);
    endtask

    task automatic bad_addr(input bit wr, input logic [7:0] pg);
        send_cmd(wr, 1'b0, pg);
        @(negedge clk);
        check(cmd_ready == 1'b1, "R2", "ready after out-of-range address", cmd_ready, 1);
        check(!ack_valid && !rd_valid, "R2", "no response to out-of-range address",
              {ack_valid, rd_valid}, 0);
        wait_idle("R2");
    endtask

    initial begin
        for (int i = 0; i < 64; i++) ref_mem[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready == 1'b1, "R1", "cmd_ready after reset", cmd_ready, 1);
        check({rd_valid, ack_valid, wr_stb, busy} == 4'b0, "R1", "outputs idle after reset",
              {rd_valid, ack_valid, wr_stb, busy}, 0);
        mon_on = 1'b1;
        do_read(8'h09, 1'b0, "R1");

        bad_addr(1'b1, 8'h40);
        bad_addr(1'b0, 8'h85);
        bad_addr(1'b1, 8'hC1);
        do_read(8'h00, 1'b1, "R2");

        do_write(8'h05, 1'b0, 8'h31, -1, 1'b0, "R8");
        do_read(8'h05, 1'b0, "R3");
        do_read(8'h05, 1'b1, "R4");

        do_write(8'h0A, 1'b1, 8'h42, -1, 1'b1, "R11");
        do_read(8'h08, 1'b1, "R6");

        do_write(8'h20, 1'b1, 8'h77, -1, 1'b0, "R9");
        do_read(8'h20, 1'b1, "R9");

        do_write(8'h30, 1'b1, 8'h19, 8'h32, 1'b0, "R10");
        do_read(8'h30, 1'b1, "R10");

        do_write(8'h3D, 1'b1, 8'h23, 8'h3D, 1'b0, "R10");
        do_write(8'h3F, 1'b0, 8'h64, -1, 1'b0, "R8");
        do_read(8'h3C, 1'b1, "R4");
        do_read(8'h3F, 1'b0, "R3");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", "run did not finish", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule